// File: doc/BRIEF.md
# I2C Bus-State Monitor with Start/Stop Issue

This block watches the clock and data lines of an I2C bus and keeps a bus-busy flag up to date. The flag goes up when it sees a start condition and comes down when it sees a stop condition. Both lines are first passed through a synchronizer. The same block lets a CPU put start, repeated-start and stop conditions on the bus. Software writes a busy bit and a companion control bit, and the block then pulls the lines low through open-drain enables in the correct order. A programmable hold count sets how long each phase of a condition lasts.

A second part of the block keeps an interrupt-request flag. Several transfer events can set it: the end of a byte, an address match while in slave receive, a lost arbitration while in master transmit, and a detected stop condition. Software clears it with a handshake. It must first read the flag while the flag is 1, and then write 0 to it. Byte shifting, address comparison and arbitration are done by neighbouring logic, which sends this block single-cycle pulses.

Top module: `i2c_bus_monitor`

## Requirements
- R1: A falling edge on the sampled data line while the sampled clock line is high is a start condition. It sets `busy_o` to 1 at the third rising clock edge after the line change (two synchronizer stages, then the flag register).
- R2: A rising edge on the sampled data line while the sampled clock line is high is a stop condition. It clears `busy_o` to 0 with the same latency as R1.
- R3: After reset, `busy_o`, `irq_o`, `scl_oe` and `sda_oe` are all 0.
- R4: The generator must be idle, and `mst`=1 and `trs`=1. A write (`wr_en`) with `wr_busy`=1 and `wr_scp`=0 then raises `sda_oe` alone for `cfg_hold`+1 cycles, and after that raises `scl_oe` as well. Both enables stay high until the next command.
- R5: The same write as in R4, made while the block holds the bus (both enables high), makes a repeated start. Each step lasts `cfg_hold`+1 cycles, in this order: SDA released with SCL held; both released; SDA low with SCL released; then both held again.
- R6: While the block holds the bus, a write with `wr_busy`=0, `wr_scp`=0 and `mst`=1 releases SCL first. SDA stays low for `cfg_hold`+1 cycles and is then released too, which is seen as a stop condition.
- R7: A write with `wr_scp`=1 changes neither enable, whatever `wr_busy` holds.
- R8: With `mst`=0 the busy bit cannot be written, so no condition is issued. A start also needs `trs`=1.
- R9: At a rising edge, `irq_o` becomes 1 when any of these is true: `byte_done`; `addr_match` with `mst`=0 and `trs`=0; `arb_lost` with `mst`=1 and `trs`=1; a detected stop condition. `addr_match` and `arb_lost` under other mode bits have no effect.
- R10: Reading the flag (`irq_rd`) while `irq_o` is 1 arms a clear. Any write (`irq_wr`) uses up the arm. A write of `irq_wdata`=0 clears the flag only if the arm was set before that write, so a write of 0 with no arm leaves the flag at 1.
- R11: If a setting event from R9 falls in the same cycle as a clearing write, the flag stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Clock line as seen on the bus |
| sda_i | input | 1 | Data line as seen on the bus |
| scl_oe | output | 1 | 1 pulls the clock line low |
| sda_oe | output | 1 | 1 pulls the data line low |
| cfg_hold | input | 8 | Phase length minus one, in clock cycles |
| mst | input | 1 | Master mode bit |
| trs | input | 1 | Transmit mode bit |
| wr_en | input | 1 | Strobe for a write of the busy/control pair |
| wr_busy | input | 1 | Busy bit value being written |
| wr_scp | input | 1 | Control bit value being written; 0 enables the condition |
| busy_o | output | 1 | Bus-busy flag |
| irq_rd | input | 1 | Software read of the interrupt flag |
| irq_wr | input | 1 | Software write of the interrupt flag |
| irq_wdata | input | 1 | Value written to the interrupt flag |
| byte_done | input | 1 | End-of-byte pulse |
| addr_match | input | 1 | Slave or general-call address match pulse |
| arb_lost | input | 1 | Arbitration-lost pulse |
| irq_o | output | 1 | Interrupt-request flag |

## Verification
A setting event for the interrupt flag and the software write that clears it can land in the same cycle. The bench provokes this by arming a clear with a read, then raising `byte_done` in the very cycle of the clearing write. The result is judged correct when the flag is still 1 afterwards. A plain write of 0 that follows must also leave the flag at 1, because that write used up the arm; a fresh read followed by a write is then needed to clear the flag. The stop that the block generates itself is also used: its stop detection sets the flag while the busy flag falls, so both effects are checked together.

// File: rtl/i2cbm_pkg.sv
package i2cbm_pkg;
    typedef enum logic [2:0] {
        G_IDLE,
        G_START,
        G_HELD,
        G_RS_REL,
        G_RS_SCL,
        G_STOP
    } gen_state_e;
endpackage

// File: rtl/i2cbm_monitor.sv
module i2cbm_monitor #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic start_det,
    output logic stop_det,
    output logic busy
);
    typedef struct packed {
        logic [STAGES-1:0] scl;
        logic [STAGES-1:0] sda;
        logic              scl_prev;
        logic              sda_prev;
        logic              busy;
    } mon_t;

    mon_t s_d, s_q;
    logic scl_s, sda_s;

    assign scl_s = s_q.scl[STAGES-1];
    assign sda_s = s_q.sda[STAGES-1];

    always_comb begin
        start_det = scl_s && s_q.scl_prev && s_q.sda_prev && !sda_s;
        stop_det  = scl_s && s_q.scl_prev && !s_q.sda_prev && sda_s;
        s_d          = s_q;
        s_d.scl      = {s_q.scl[STAGES-2:0], scl_i};
        s_d.sda      = {s_q.sda[STAGES-2:0], sda_i};
        s_d.scl_prev = scl_s;
        s_d.sda_prev = sda_s;
        if (start_det)     s_d.busy = 1'b1;
        else if (stop_det) s_d.busy = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.scl      <= '1;
            s_q.sda      <= '1;
            s_q.scl_prev <= 1'b1;
            s_q.sda_prev <= 1'b1;
            s_q.busy     <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy = s_q.busy;

    // R1
    busy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> busy);
    // R2
    busy_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !busy);
endmodule

// File: rtl/i2cbm_gen.sv
module i2cbm_gen
    import i2cbm_pkg::*;
#(
    parameter int HOLD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HOLD_W-1:0] cfg_hold,
    input  logic              mst,
    input  logic              trs,
    input  logic              wr_en,
    input  logic              wr_busy,
    input  logic              wr_scp,
    output logic              scl_oe,
    output logic              sda_oe
);
    typedef struct packed {
        gen_state_e        st;
        logic [HOLD_W-1:0] cnt;
    } gen_t;

    gen_t g_d, g_q;
    logic cmd_ok, phase_end;

    always_comb begin
        cmd_ok    = wr_en && !wr_scp && mst;
        phase_end = (g_q.cnt == cfg_hold);
        g_d       = g_q;
        unique case (g_q.st)
            G_IDLE: begin
                g_d.cnt = '0;
                if (cmd_ok && wr_busy && trs) g_d.st = G_START;
            end
            G_HELD: begin
                g_d.cnt = '0;
                if (cmd_ok && wr_busy && trs) g_d.st = G_RS_REL;
                else if (cmd_ok && !wr_busy)  g_d.st = G_STOP;
            end
            default: begin
                if (phase_end) begin
                    g_d.cnt = '0;
                    unique case (g_q.st)
                        G_START:  g_d.st = G_HELD;
                        G_RS_REL: g_d.st = G_RS_SCL;
                        G_RS_SCL: g_d.st = G_START;
                        default:  g_d.st = G_IDLE;
                    endcase
                end else begin
                    g_d.cnt = g_q.cnt + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            g_q.st  <= G_IDLE;
            g_q.cnt <= '0;
        end else begin
            g_q <= g_d;
        end
    end

    assign sda_oe = (g_q.st == G_START) || (g_q.st == G_HELD) || (g_q.st == G_STOP);
    assign scl_oe = (g_q.st == G_HELD) || (g_q.st == G_RS_REL);

    // R4
    scl_after_sda_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_oe) |-> sda_oe);
    // R7
    scp_noop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_scp && (g_q.st == G_IDLE || g_q.st == G_HELD)) |=> $stable(g_q.st));
    // R8
    slave_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !mst && g_q.st == G_IDLE) |=> g_q.st == G_IDLE);
endmodule

// File: rtl/i2cbm_irq.sv
module i2cbm_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic mst,
    input  logic trs,
    input  logic byte_done,
    input  logic addr_match,
    input  logic arb_lost,
    input  logic stop_det,
    input  logic irq_rd,
    input  logic irq_wr,
    input  logic irq_wdata,
    output logic irq
);
    typedef struct packed {
        logic flag;
        logic arm;
    } irq_t;

    irq_t r_d, r_q;
    logic set_evt, clr_req;

    always_comb begin
        set_evt = byte_done
                || (addr_match && !mst && !trs)
                || (arb_lost && mst && trs)
                || stop_det;
        clr_req = irq_wr && !irq_wdata && r_q.arm;
        r_d     = r_q;
        if (irq_rd && r_q.flag) r_d.arm = 1'b1;
        if (irq_wr)             r_d.arm = 1'b0;
        if (set_evt)            r_d.flag = 1'b1;
        else if (clr_req)       r_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign irq = r_q.flag;

    // R9
    irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> irq);
    // R10
    noarm_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !r_q.arm && !set_evt) |=> irq);
    // R11
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_evt && clr_req) |=> irq);
endmodule

// File: rtl/i2c_bus_monitor.sv
module i2c_bus_monitor #(
    parameter int HOLD_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_oe,
    output logic              sda_oe,
    input  logic [HOLD_W-1:0] cfg_hold,
    input  logic              mst,
    input  logic              trs,
    input  logic              wr_en,
    input  logic              wr_busy,
    input  logic              wr_scp,
    output logic              busy_o,
    input  logic              irq_rd,
    input  logic              irq_wr,
    input  logic              irq_wdata,
    input  logic              byte_done,
    input  logic              addr_match,
    input  logic              arb_lost,
    output logic              irq_o
);
    logic start_det, stop_det;

    i2cbm_monitor #(.STAGES(SYNC_STAGES)) u_mon (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .start_det(start_det), .stop_det(stop_det), .busy(busy_o)
    );

    i2cbm_gen #(.HOLD_W(HOLD_W)) u_gen (
        .clk(clk), .rst_n(rst_n), .cfg_hold(cfg_hold), .mst(mst), .trs(trs),
        .wr_en(wr_en), .wr_busy(wr_busy), .wr_scp(wr_scp),
        .scl_oe(scl_oe), .sda_oe(sda_oe)
    );

    i2cbm_irq u_irq (
        .clk(clk), .rst_n(rst_n), .mst(mst), .trs(trs),
        .byte_done(byte_done), .addr_match(addr_match), .arb_lost(arb_lost),
        .stop_det(stop_det), .irq_rd(irq_rd), .irq_wr(irq_wr),
        .irq_wdata(irq_wdata), .irq(irq_o)
    );

    // R3
    reset_idle_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (!busy_o && !irq_o && !scl_oe && !sda_oe));
endmodule

// File: tb/tb_i2c_bus_monitor.sv
module tb_i2c_bus_monitor;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_ext = 1'b1, sda_ext = 1'b1;
    logic scl_oe, sda_oe, busy_o, irq_o;
    logic [7:0] cfg_hold = 8'd3;
    logic mst = 0, trs = 0, wr_en = 0, wr_busy = 0, wr_scp = 0;
    logic irq_rd = 0, irq_wr = 0, irq_wdata = 0;
    logic byte_done = 0, addr_match = 0, arb_lost = 0;
    logic scl_line, sda_line;
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    assign scl_line = scl_ext & ~scl_oe;
    assign sda_line = sda_ext & ~sda_oe;

    always #10 clk = ~clk;

    i2c_bus_monitor dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .cfg_hold(cfg_hold),
        .mst(mst), .trs(trs), .wr_en(wr_en), .wr_busy(wr_busy), .wr_scp(wr_scp),
        .busy_o(busy_o), .irq_rd(irq_rd), .irq_wr(irq_wr), .irq_wdata(irq_wdata),
        .byte_done(byte_done), .addr_match(addr_match), .arb_lost(arb_lost),
        .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic b, input logic scp);
        wr_en = 1; wr_busy = b; wr_scp = scp;
        step(1);
        wr_en = 0; wr_busy = 0; wr_scp = 0;
    endtask

    // {rd, wr, wdata, byte_done, addr_match, arb_lost, mst, trs, exp_irq}
    localparam int NV = 23;
    localparam logic [8:0] VEC [NV] = '{
        9'b000000000, // idle
        9'b000100001, // R9 byte_done sets
        9'b010000001, // R10 write 0 without arm
        9'b100000001, // R10 read arms
        9'b010000000, // R10 clear
        9'b000010001, // R9 address match in slave receive
        9'b100000001, // arm
        9'b010100001, // R11 set wins over clear
        9'b010000001, // R10 arm was used up
        9'b100000001, // arm
        9'b011000001, // write 1 uses arm, no clear
        9'b010000001, // R10 no arm left
        9'b100000001, // arm
        9'b010000000, // clear
        9'b000010100, // R9 addr_match in master ignored
        9'b000001100, // R9 arb_lost in master receive ignored
        9'b000001111, // R9 arb_lost in master transmit sets
        9'b100000111, // arm
        9'b010000000, // clear
        9'b000010010, // R9 addr_match in slave transmit ignored
        9'b100000000, // R10 read while 0 does not arm
        9'b000100001, // set
        9'b010000001  // R10 still no arm
    };

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        step(3);
        chk("R3 reset", {busy_o, irq_o, scl_oe, sda_oe}, 4'b0000);
        rst_n = 1;
        step(2);
        chk("R3 after release", {busy_o, irq_o, scl_oe, sda_oe}, 4'b0000);

        for (int i = 0; i < NV; i++) begin
            {irq_rd, irq_wr, irq_wdata, byte_done, addr_match, arb_lost, mst, trs} = VEC[i][8:1];
            step(1);
            chk($sformatf("R9/R10/R11 vector %0d", i), {3'b0, irq_o}, {3'b0, VEC[i][0]});
        end
        {irq_rd, irq_wr, irq_wdata, byte_done, addr_match, arb_lost, mst, trs} = '0;
        // clear flag left set
        irq_rd = 1; step(1); irq_rd = 0; irq_wr = 1; step(1); irq_wr = 0;
        chk("R10 cleared", {3'b0, irq_o}, 4'b0000);

        // external start: busy at third edge
        sda_ext = 0;
        step(2);
        chk("R1 not yet", {3'b0, busy_o}, 4'b0000);
        step(1);
        chk("R1 busy set", {3'b0, busy_o}, 4'b0001);
        sda_ext = 1;
        step(2);
        chk("R2 not yet", {3'b0, busy_o}, 4'b0001);
        step(1);
        chk("R2 busy clear", {busy_o, irq_o, 2'b0}, 4'b0100);
        irq_rd = 1; step(1); irq_rd = 0; irq_wr = 1; step(1); irq_wr = 0;

        // R7 scp=1 writes do nothing
        mst = 1; trs = 1;
        bus_write(1, 1);
        step(5);
        chk("R7 scp set", {busy_o, 1'b0, scl_oe, sda_oe}, 4'b0000);
        // R8 slave mode and receive mode block start
        mst = 0;
        bus_write(1, 0);
        step(5);
        chk("R8 slave", {busy_o, 1'b0, scl_oe, sda_oe}, 4'b0000);
        mst = 1; trs = 0;
        bus_write(1, 0);
        step(5);
        chk("R8 receive", {busy_o, 1'b0, scl_oe, sda_oe}, 4'b0000);

        // R4 start with hold 3: 4 cycles SDA only
        trs = 1;
        bus_write(1, 0);
        chk("R4 sda first", {2'b0, scl_oe, sda_oe}, 4'b0001);
        step(3);
        chk("R4 sda phase end", {2'b0, scl_oe, sda_oe}, 4'b0001);
        step(1);
        chk("R4 held", {busy_o, 1'b0, scl_oe, sda_oe}, 4'b1011);

        // R8 stop write in slave mode while held is ignored
        mst = 0;
        bus_write(0, 0);
        step(5);
        chk("R8 slave stop", {busy_o, 1'b0, scl_oe, sda_oe}, 4'b1011);
        mst = 1;

        // R5 repeated start
        bus_write(1, 0);
        chk("R5 sda release", {2'b0, scl_oe, sda_oe}, 4'b0010);
        step(4);
        chk("R5 both release", {2'b0, scl_oe, sda_oe}, 4'b0000);
        step(4);
        chk("R5 sda low", {2'b0, scl_oe, sda_oe}, 4'b0001);
        step(4);
        chk("R5 held", {busy_o, irq_o, scl_oe, sda_oe}, 4'b1011);

        // R6 stop
        bus_write(0, 0);
        chk("R6 scl release", {2'b0, scl_oe, sda_oe}, 4'b0001);
        step(3);
        chk("R6 sda still low", {2'b0, scl_oe, sda_oe}, 4'b0001);
        step(1);
        chk("R6 sda release", {2'b0, scl_oe, sda_oe}, 4'b0000);
        step(4);
        chk("R6/R2/R9 stop seen", {busy_o, irq_o, scl_oe, sda_oe}, 4'b0100);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule